// File: doc/BRIEF.md
# Masked Set/Clear Compare Port

This block drives an 8-bit output port from two 16-bit compare values that are checked against a free-running 16-bit timer. One compare value is the set trigger and the other is the clear trigger. Each trigger has its own 8-bit mask. When the timer reaches the set value, every port bit selected by the set mask goes high in one step. When the timer reaches the clear value, every bit selected by the clear mask goes low in one step. This lets several pins switch on the same timer tick, which suits multi-phase pulse patterns.

Software reaches the block through a simple write bus. The bus can load either compare value, either mask or the port level itself, and it clears the two sticky interrupt flags. The current port level is always visible on the port output, so that output also serves as the read-back path.

Top module: `mask_setclr_compare`

## Requirements
- R1: One clock edge after a cycle in which `timer_i` equals the set compare value, every port bit whose set-mask bit is 1 reads 1 on `port_o`.
- R2: One clock edge after a cycle in which `timer_i` equals the clear compare value, every port bit whose clear-mask bit is 1 reads 0 on `port_o`.
- R3: A compare match leaves each port bit whose mask bit for that match is 0 at its previous level. With no match and no port write, the port holds its value.
- R4: When both matches occur in the same cycle and both masks select a bit, that bit ends at 0, because clear wins over set.
- R5: A bus write to address 4 loads `wr_data_i[7:0]` into the port, and `port_o` shows the new level after the next clock edge.
- R6: A port write in the same cycle as a match is applied first. The masked match result then overrides only the bits that its masks select.
- R7: A set match sets `irq_set_o` and a clear match sets `irq_clr_o`. Each flag stays high until a bus write to address 5 carries a 1 in its bit position: bit 0 clears the set flag and bit 1 clears the clear flag. A match in the same cycle as that write leaves its flag set. A match sets its flag even when its mask is zero.
- R8: Reset clears the port, both masks, both compare values and both flags to zero.
- R9: Bus writes to address 0 load the set compare value and writes to address 1 load the clear compare value, both from `wr_data_i[15:0]`. Writes to addresses 2 and 3 load the set mask and the clear mask from `wr_data_i[7:0]`. A newly written compare value takes part in matching from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| timer_i | input | 16 | Timer count compared against both compare values |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 3 | Bus write address |
| wr_data_i | input | 16 | Bus write data |
| port_o | output | 8 | Current port level (also the read-back value) |
| irq_set_o | output | 1 | Sticky set-match interrupt request |
| irq_clr_o | output | 1 | Sticky clear-match interrupt request |

## Verification
Three same-cycle collisions are the hardest cases to reach from the ports. The first is a set and a clear match on the same tick. The second is a direct port write that lands together with a match. The third is a flag clear that coincides with a new match. Each needs the timer and the bus lined up on exactly the same edge. The stimulus reaches the first collision by rewriting the clear compare value to equal the set value. It reaches the other two by driving the bus write and the matching timer value together in one cycle. The sequence runs over 64 mask and port patterns, and the bench computes each expected level arithmetically.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    A_SETCMP = 3'd0,
    A_CLRCMP = 3'd1,
    A_SETMSK = 3'd2,
    A_CLRMSK = 3'd3,
    A_PORT   = 3'd4,
    A_IRQ    = 3'd5
  } smc_addr_e;

  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned IDX_SET = 0;
  localparam int unsigned IDX_CLR = 1;
endpackage

// File: rtl/smc_rst_sync.sv
module smc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/smc_regs.sv
module smc_regs
  import smc_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [TW-1:0] wr_data_i,
  output logic [TW-1:0] set_cmp_o,
  output logic [TW-1:0] clr_cmp_o,
  output logic [PW-1:0] set_msk_o,
  output logic [PW-1:0] clr_msk_o,
  output logic          port_wr_o,
  output logic [PW-1:0] port_wdata_o,
  output logic [1:0]    irq_w1c_o
);
  logic [TW-1:0] set_cmp_q, set_cmp_n, clr_cmp_q, clr_cmp_n;
  logic [PW-1:0] set_msk_q, set_msk_n, clr_msk_q, clr_msk_n;
  logic en_setcmp, en_clrcmp, en_setmsk, en_clrmsk;
  smc_addr_e addr;

  assign addr = smc_addr_e'(wr_addr_i);

  always_comb begin
    en_setcmp = 1'b0;
    en_clrcmp = 1'b0;
    en_setmsk = 1'b0;
    en_clrmsk = 1'b0;
    port_wr_o = 1'b0;
    irq_w1c_o = 2'b00;
    if (wr_en_i) begin
      case (addr)
        A_SETCMP: en_setcmp = 1'b1;
        A_CLRCMP: en_clrcmp = 1'b1;
        A_SETMSK: en_setmsk = 1'b1;
        A_CLRMSK: en_clrmsk = 1'b1;
        A_PORT:   port_wr_o = 1'b1;
        A_IRQ:    irq_w1c_o = wr_data_i[1:0];
        default:  ;
      endcase
    end
    set_cmp_n = wr_data_i;
    clr_cmp_n = wr_data_i;
    set_msk_n = wr_data_i[PW-1:0];
    clr_msk_n = wr_data_i[PW-1:0];
  end

  assign port_wdata_o = wr_data_i[PW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_cmp_q <= '0;
      clr_cmp_q <= '0;
      set_msk_q <= '0;
      clr_msk_q <= '0;
    end else begin
      if (en_setcmp) set_cmp_q <= set_cmp_n;
      if (en_clrcmp) clr_cmp_q <= clr_cmp_n;
      if (en_setmsk) set_msk_q <= set_msk_n;
      if (en_clrmsk) clr_msk_q <= clr_msk_n;
    end
  end

  assign set_cmp_o = set_cmp_q;
  assign clr_cmp_o = clr_cmp_q;
  assign set_msk_o = set_msk_q;
  assign clr_msk_o = clr_msk_q;

  // R9: a write to the set compare address shows up in the register on the next edge
  p_setcmp_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |=> (set_cmp_o == $past(wr_data_i)));
endmodule

// File: rtl/smc_match.sv
module smc_match #(
  parameter int unsigned TW = 16
) (
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] cmp_i,
  output logic          hit_o
);
  assign hit_o = (timer_i == cmp_i);
endmodule

// File: rtl/smc_port.sv
module smc_port #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_wr_i,
  input  logic [PW-1:0] port_wdata_i,
  input  logic          set_hit_i,
  input  logic          clr_hit_i,
  input  logic [PW-1:0] set_msk_i,
  input  logic [PW-1:0] clr_msk_i,
  input  logic [1:0]    irq_w1c_i,
  output logic [PW-1:0] port_o,
  output logic [1:0]    irq_o
);
  logic [PW-1:0] port_q, port_n;
  logic [1:0]    irq_q, irq_n;
  logic          port_en, irq_en;

  always_comb begin
    port_n = port_q;
    if (port_wr_i) port_n = port_wdata_i;
    if (set_hit_i) port_n = port_n | set_msk_i;
    if (clr_hit_i) port_n = port_n & ~clr_msk_i;
    port_en = port_wr_i | set_hit_i | clr_hit_i;
  end

  always_comb begin
    irq_n  = (irq_q & ~irq_w1c_i) | {clr_hit_i, set_hit_i};
    irq_en = (|irq_w1c_i) | set_hit_i | clr_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
      irq_q  <= '0;
    end else begin
      if (port_en) port_q <= port_n;
      if (irq_en)  irq_q  <= irq_n;
    end
  end

  assign port_o = port_q;
  assign irq_o  = irq_q;

  p_set_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit_i && !clr_hit_i) |=> ((port_q & $past(set_msk_i)) == $past(set_msk_i)));

  p_clr_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit_i |=> ((port_q & $past(clr_msk_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_wr_i && !set_hit_i && !clr_hit_i) |=> (port_q == $past(port_q)));

  p_unmasked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_wr_i && (set_hit_i || clr_hit_i)) |=>
      (((port_q ^ $past(port_q)) & ~($past(set_msk_i) | $past(clr_msk_i))) == '0));

  p_port_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i |=> (((port_q ^ $past(port_wdata_i)) & ~($past(set_msk_i) | $past(clr_msk_i))) == '0));

  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit_i |=> irq_q[0]);

  p_irq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit_i |=> irq_q[1]);
endmodule

// File: rtl/mask_setclr_compare.sv
module mask_setclr_compare
  import smc_pkg::*;
#(
  parameter int unsigned TW = 16,
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] timer_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [TW-1:0] wr_data_i,
  output logic [PW-1:0] port_o,
  output logic          irq_set_o,
  output logic          irq_clr_o
);
  logic          rst_n;
  logic [TW-1:0] cmp_val [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [PW-1:0] set_msk, clr_msk, port_wdata;
  logic          port_wr;
  logic [1:0]    irq_w1c, irq;

  smc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  smc_regs #(.TW(TW), .PW(PW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .set_cmp_o    (cmp_val[IDX_SET]),
    .clr_cmp_o    (cmp_val[IDX_CLR]),
    .set_msk_o    (set_msk),
    .clr_msk_o    (clr_msk),
    .port_wr_o    (port_wr),
    .port_wdata_o (port_wdata),
    .irq_w1c_o    (irq_w1c)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    smc_match #(.TW(TW)) u_match (
      .timer_i (timer_i),
      .cmp_i   (cmp_val[g]),
      .hit_o   (hit[g])
    );
  end

  smc_port #(.PW(PW)) u_port (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .port_wr_i    (port_wr),
    .port_wdata_i (port_wdata),
    .set_hit_i    (hit[IDX_SET]),
    .clr_hit_i    (hit[IDX_CLR]),
    .set_msk_i    (set_msk),
    .clr_msk_i    (clr_msk),
    .irq_w1c_i    (irq_w1c),
    .port_o       (port_o),
    .irq_o        (irq)
  );

  assign irq_set_o = irq[0];
  assign irq_clr_o = irq[1];

  // R4: a bit selected by both masks ends low when both matches fire together
  p_clear_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hit[IDX_SET] && hit[IDX_CLR]) |=> ((port_o & $past(set_msk & clr_msk)) == '0));
endmodule

// File: tb/tb_mask_setclr_compare.sv
module tb_mask_setclr_compare;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] timer_i;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic [7:0]  port_o;
  logic        irq_set_o, irq_clr_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [15:0] IDLE_T = 16'hFFFF;

  always #5 clk = ~clk;

  mask_setclr_compare dut (
    .clk_i(clk), .rst_ni(rst_ni), .timer_i(timer_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .port_o(port_o),
    .irq_set_o(irq_set_o), .irq_clr_o(irq_clr_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick(input logic [15:0] t);
    timer_i = t;
    @(negedge clk);
    timer_i = IDLE_T;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] sm, cm, p0, d, exp;
    logic [15:0] cs, cc;
    rst_ni = 1'b0; timer_i = IDLE_T; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R8 port", {8'h0, port_o}, 16'h0);
    chk("R8 irq", {14'h0, irq_clr_o, irq_set_o}, 16'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 port after release", {8'h0, port_o}, 16'h0);
    // R8: compare values and masks are zero, so timer 0 hits both without touching the port
    tick(16'h0000);
    chk("R8 zero masks keep port", {8'h0, port_o}, 16'h0);
    chk("R8 zero compares hit", {14'h0, irq_clr_o, irq_set_o}, 16'h3);
    wr(3'd5, 16'h3);
    chk("R7 w1c both", {14'h0, irq_clr_o, irq_set_o}, 16'h0);

    for (int i = 0; i < 64; i++) begin
      sm = 8'(i * 37 + 5);
      cm = 8'(i * 91) ^ 8'h3C;
      p0 = 8'(i * 13 + 1);
      cs = 16'h0100 + 16'(i);
      cc = 16'h0200 + 16'(i);
      wr(3'd0, cs); wr(3'd1, cc); wr(3'd2, {8'h0, sm}); wr(3'd3, {8'h0, cm});
      wr(3'd4, {8'hA5, p0});
      chk("R5 port write", {8'h0, port_o}, {8'h0, p0});

      tick(cs);
      exp = p0 | sm;
      chk("R1 R3 set match", {8'h0, port_o}, {8'h0, exp});
      chk("R7 set flag", {14'h0, irq_clr_o, irq_set_o}, 16'h1);

      tick(cc);
      exp = exp & ~cm;
      chk("R2 R3 clear match", {8'h0, port_o}, {8'h0, exp});
      chk("R7 clear flag", {14'h0, irq_clr_o, irq_set_o}, 16'h3);

      // R7: w1c of both flags together with a new set match
      wr_en_i = 1'b1; wr_addr_i = 3'd5; wr_data_i = 16'h3;
      tick(cs);
      wr_en_i = 1'b0;
      exp = exp | sm;
      chk("R7 match beats w1c", {14'h0, irq_clr_o, irq_set_o}, 16'h1);
      chk("R1 set again", {8'h0, port_o}, {8'h0, exp});

      // R6: port write and set match on the same edge
      d = ~p0;
      wr_en_i = 1'b1; wr_addr_i = 3'd4; wr_data_i = {8'h00, d};
      tick(cs);
      wr_en_i = 1'b0;
      exp = d | sm;
      chk("R6 write then set", {8'h0, port_o}, {8'h0, exp});

      // R4: both compares equal, then fire together
      wr(3'd1, cs);
      wr(3'd4, {8'h0, p0});
      tick(cs);
      exp = (p0 | sm) & ~cm;
      chk("R4 clear wins", {8'h0, port_o}, {8'h0, exp});

      // R3: idle cycles hold the port
      tick(IDLE_T);
      chk("R3 hold", {8'h0, port_o}, {8'h0, exp});

      // R9: rewrite the clear compare value and confirm it is matched next
      wr(3'd1, cc);
      wr(3'd4, 16'h00FF);
      tick(cc);
      chk("R9 clear compare reload", {8'h0, port_o}, {8'h0, ~cm});

      wr(3'd5, 16'h3);
      chk("R7 flags cleared", {14'h0, irq_clr_o, irq_set_o}, 16'h0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule